// File: doc/BRIEF.md
# Bus Listen Address Logic

This block decides whether the instrument is currently addressed as a listener on a parallel instrument bus. It watches the seven data lines, which are active-low, together with the attention line. When attention is asserted (low), the bus carries command characters. On each accept strobe from the neighbouring handshake block, the current command character is decoded.

A listen address matching the rear-panel address switches sets a listen flag. The unlisten character clears it. Every other command passes without effect.

Data-mode strobes, where attention is high, never touch the flag. A power-on reset clears it, so the instrument never starts out as a listener.

Top module: `listen_addr_unit`

## Requirements
- R1: `addrMatch` is high whenever the inverted data lines 5..1 (`~busDataN[4:0]`) equal `addrSw`, independent of attention, strobe and the other data lines.
- R2: With `atnN` low, an `acceptStb` on a character (`~busDataN`) whose bits 6..5 equal 2'b01 and whose bits 4..0 equal `addrSw` sets `listenOn` at that clock edge, provided `addrSw` is not 5'b11111.
- R3: With `atnN` low, an `acceptStb` on the unlisten character 0x3F (bus lines 7'h40) clears `listenOn` at that clock edge.
- R4: With `atnN` low, a strobe on any other command character leaves `listenOn` unchanged. This covers talk addresses (bits 6..5 = 2'b10), listen addresses for other devices, and characters with bits 6..5 = 2'b00 or 2'b11 other than 0x3F.
- R5: With `atnN` high (data mode), `acceptStb` has no effect on `listenOn`, whatever the data lines carry.
- R6: While `porN` is low at a clock edge, `listenOn` is cleared. After reset, it reads 0 until a valid listen command arrives.
- R7: Without `acceptStb`, `listenOn` holds its value, even if the bus carries the device's own listen address in command mode.
- R8: With `addrSw` = 5'b11111, the character 0x3F acts only as unlisten, so `listenOn` can never be set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| porN | input | 1 | Power-on reset, active low, synchronous |
| busDataN | input | 7 | Bus data lines, active low; bit 0 is line 1 |
| atnN | input | 1 | Attention line, active low (low = command mode) |
| acceptStb | input | 1 | Single-cycle accept pulse from the handshake block |
| addrSw | input | 5 | Address switch setting |
| addrMatch | output | 1 | High when data lines 5..1 equal the switch setting |
| listenOn | output | 1 | Listen flag |

## Verification
The bench builds the block with its default widths: seven data lines, a five-bit address and the listen group code 2'b01. This puts the full listen, talk and unlisten command space within reach, so every character class can be driven against a fixed switch value.

A second switch value of all ones reaches the corner where the device's listen address would coincide with unlisten. Resets are applied both with the flag clear and with it set.

// File: rtl/listen_addr_pkg.sv
package listen_addr_pkg;

  // Decode results handed from datapath to control
  typedef struct packed {
    logic addrHit;
    logic grpListen;
    logic isUnlisten;
  } cmdDecS;

  // Strobes handed from control back to datapath
  typedef struct packed {
    logic setLsn;
    logic clrLsn;
  } lsnCtlS;

endpackage

// File: rtl/listen_addr_dp.sv
module listen_addr_dp
  import listen_addr_pkg::*;
#(
  parameter int DATA_W = 7,
  parameter int ADDR_W = 5,
  parameter logic [DATA_W-ADDR_W-1:0] LISTEN_GRP = 2'b01
) (
  input  logic              clk,
  input  logic              porN,
  input  logic [DATA_W-1:0] busDataN,
  input  logic [ADDR_W-1:0] addrSw,
  input  lsnCtlS            ctl,
  output cmdDecS            dec,
  output logic              addrMatch,
  output logic              listenOn
);

  localparam int GRP_W = DATA_W - ADDR_W;

  logic [DATA_W-1:0] charTrue;
  logic [GRP_W-1:0]  charGrp;
  logic [ADDR_W-1:0] charAddr;
  logic              lsnQ;

  // Bus lines are active low: restore true polarity before decoding
  assign charTrue = ~busDataN;
  assign charGrp  = charTrue[DATA_W-1:ADDR_W];
  assign charAddr = charTrue[ADDR_W-1:0];

  always_comb begin
    dec.addrHit    = (charAddr == addrSw);
    dec.grpListen  = (charGrp == LISTEN_GRP);
    dec.isUnlisten = dec.grpListen && (&charAddr);
  end

  assign addrMatch = dec.addrHit;

  // Clear takes priority over set
  always_ff @(posedge clk) begin
    if (!porN)           lsnQ <= 1'b0;
    else if (ctl.clrLsn) lsnQ <= 1'b0;
    else if (ctl.setLsn) lsnQ <= 1'b1;
  end

  assign listenOn = lsnQ;

endmodule

// File: rtl/listen_addr_ctl.sv
module listen_addr_ctl
  import listen_addr_pkg::*;
(
  input  logic   atnN,
  input  logic   acceptStb,
  input  cmdDecS dec,
  output lsnCtlS ctl
);

  logic cmdFire;

  // Only strobes taken in command mode may act on the flag
  assign cmdFire = acceptStb && !atnN;

  always_comb begin
    ctl.clrLsn = cmdFire && dec.isUnlisten;
    ctl.setLsn = cmdFire && dec.grpListen && dec.addrHit && !dec.isUnlisten;
  end

endmodule

// File: rtl/listen_addr_unit.sv
module listen_addr_unit
  import listen_addr_pkg::*;
#(
  parameter int DATA_W = 7,
  parameter int ADDR_W = 5,
  parameter logic [DATA_W-ADDR_W-1:0] LISTEN_GRP = 2'b01
) (
  input  logic              clk,
  input  logic              porN,
  input  logic [DATA_W-1:0] busDataN,
  input  logic              atnN,
  input  logic              acceptStb,
  input  logic [ADDR_W-1:0] addrSw,
  output logic              addrMatch,
  output logic              listenOn
);

  cmdDecS decW;
  lsnCtlS ctlW;

  listen_addr_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LISTEN_GRP(LISTEN_GRP)
  ) u_dp (
    .clk(clk), .porN(porN), .busDataN(busDataN), .addrSw(addrSw),
    .ctl(ctlW), .dec(decW), .addrMatch(addrMatch), .listenOn(listenOn)
  );

  listen_addr_ctl u_ctl (
    .atnN(atnN), .acceptStb(acceptStb), .dec(decW), .ctl(ctlW)
  );

endmodule

// File: rtl/listen_addr_chk.sv
module listen_addr_chk #(
  parameter int DATA_W = 7,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              porN,
  input logic [DATA_W-1:0] busDataN,
  input logic              atnN,
  input logic              acceptStb,
  input logic [ADDR_W-1:0] addrSw,
  input logic              listenOn
);

  localparam logic [DATA_W-1:0] UNL_CHAR = 7'h3F;

  logic ownListen;
  assign ownListen = ((~busDataN) == {2'b01, addrSw}) && !(&addrSw);

  AST_SET_ON_OWN_ADDR: assert property (@(posedge clk) disable iff (!porN)
    acceptStb && !atnN && ownListen |=> listenOn);                       // R2

  AST_CLR_ON_UNLISTEN: assert property (@(posedge clk) disable iff (!porN)
    acceptStb && !atnN && ((~busDataN) == UNL_CHAR) |=> !listenOn);      // R3

  AST_DATA_MODE_HOLD: assert property (@(posedge clk) disable iff (!porN)
    porN && atnN |=> $stable(listenOn));                                 // R5

  AST_NO_STB_HOLD: assert property (@(posedge clk) disable iff (!porN)
    porN && !acceptStb |=> $stable(listenOn));                           // R7

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !porN |=> !listenOn);                                                // R6

  AST_ALLONES_NEVER_SET: assert property (@(posedge clk) disable iff (!porN)
    (&addrSw) && !listenOn && $stable(addrSw) |=> !listenOn);            // R8

endmodule

bind listen_addr_unit listen_addr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .porN(porN), .busDataN(busDataN), .atnN(atnN),
  .acceptStb(acceptStb), .addrSw(addrSw), .listenOn(listenOn)
);

// File: tb/listen_addr_unit_bench.sv
module listen_addr_unit_bench;

  logic       clk = 1'b0;
  logic       porN = 1'b0;
  logic [6:0] busDataN = 7'h7F;
  logic       atnN = 1'b1;
  logic       acceptStb = 1'b0;
  logic [4:0] addrSw = 5'h0D;
  logic       addrMatch;
  logic       listenOn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  listen_addr_unit u_listen_addr_unit (
    .clk(clk), .porN(porN), .busDataN(busDataN), .atnN(atnN),
    .acceptStb(acceptStb), .addrSw(addrSw), .addrMatch(addrMatch),
    .listenOn(listenOn)
  );

  // Vector: {atnN, char(7), stb, expListen, reqNum(4)}, addrSw = 0x0D
  localparam int NV = 14;
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 7'h2D, 1'b1, 1'b1, 4'd2},  // R2 own listen address
    {1'b0, 7'h4D, 1'b1, 1'b1, 4'd4},  // R4 talk address ignored
    {1'b0, 7'h2E, 1'b1, 1'b1, 4'd4},  // R4 foreign listen address
    {1'b0, 7'h5F, 1'b1, 1'b1, 4'd4},  // R4 untalk ignored
    {1'b0, 7'h0D, 1'b1, 1'b1, 4'd4},  // R4 group 00 ignored
    {1'b1, 7'h3F, 1'b1, 1'b1, 4'd5},  // R5 unlisten pattern in data mode
    {1'b0, 7'h3F, 1'b0, 1'b1, 4'd7},  // R7 unlisten without strobe
    {1'b0, 7'h3F, 1'b1, 1'b0, 4'd3},  // R3 unlisten clears
    {1'b0, 7'h4D, 1'b1, 1'b0, 4'd4},  // R4 talk does not set
    {1'b0, 7'h2D, 1'b0, 1'b0, 4'd7},  // R7 own address, no strobe
    {1'b1, 7'h2D, 1'b1, 1'b0, 4'd5},  // R5 own address in data mode
    {1'b0, 7'h6D, 1'b1, 1'b0, 4'd4},  // R4 group 11 ignored
    {1'b0, 7'h2D, 1'b1, 1'b1, 4'd2},  // R2 set again
    {1'b0, 7'h3F, 1'b1, 1'b0, 4'd3}   // R3 clear again
  };

  task automatic check(input bit got, input bit exp, input int req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  // Drive after negedge, check match before the edge, listen flag after it
  task automatic apply(input bit a, input logic [6:0] ch, input bit s,
                       input bit expL, input int req);
    @(negedge clk);
    atnN = a; busDataN = ~ch; acceptStb = s;
    #1;
    check(addrMatch, ch[4:0] == addrSw, 1, "address match"); // R1
    @(posedge clk);
    #1;
    acceptStb = 1'b0;
    check(listenOn, expL, req, "listen flag");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(listenOn, 1'b0, 6, "after power-on reset"); // R6
    @(negedge clk); porN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [13:0] v;
      v = VEC[i];
      apply(v[13], v[12:6], v[5], v[4], int'(v[3:0]));
    end

    // R6: reset while listening clears the flag; strobe during reset ignored
    apply(1'b0, 7'h2D, 1'b1, 1'b1, 2);
    @(negedge clk); porN = 1'b0; atnN = 1'b0; busDataN = ~7'h2D; acceptStb = 1'b1;
    @(posedge clk); #1; acceptStb = 1'b0;
    check(listenOn, 1'b0, 6, "reset while set");
    @(negedge clk); porN = 1'b1;
    #1; check(listenOn, 1'b0, 6, "after reset release");

    // R8: all-ones switches never set the flag; 0x3F acts as unlisten
    apply(1'b0, 7'h2D, 1'b1, 1'b1, 2);
    @(negedge clk); addrSw = 5'h1F;
    apply(1'b0, 7'h3F, 1'b1, 1'b0, 8);
    apply(1'b0, 7'h3F, 1'b1, 1'b0, 8);
    apply(1'b0, 7'h5F, 1'b1, 1'b0, 8);

    // R1: match ignores upper lines and attention
    @(negedge clk); addrSw = 5'h0A; atnN = 1'b1; busDataN = ~7'h6A;
    #1; check(addrMatch, 1'b1, 1, "match with group 11 in data mode");
    busDataN = ~7'h6B;
    #1; check(addrMatch, 1'b0, 1, "mismatch on bit 0");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule